// File: doc/BRIEF.md
# Read Data Output Stage

This block sits between the read port of a memory array and the shared data bus of one memory port. Every clock edge it registers the access controls: a chip-select pair, two per-lane byte selects and the read/write direction. It then decides, per byte lane, whether the word read from the array is driven onto the bus. A static mode pin selects flow-through timing or pipelined timing. In flow-through timing the word read for an address appears in the cycle right after the edge that registered that address. In pipelined timing one more register stage is added, so everything appears one cycle later.

The stage produces an 18-bit data word and one drive indication per byte lane. The drive indication stands in for the output-enable of the tri-state pads, which lie outside this block. A lane that is not driven reads as zero on the data output. An active-low output enable acts with no clock. It blanks both lanes at once and lets them return as soon as it is released. The bus is a pure producer stream. Each lane's drive bit is its valid flag, and there is no ready input, so the bus side must take the word in the cycle it is shown.

Top module: `rd_out_stage`

## Requirements
- R1: While reset is asserted and after it is released, with no access accepted, both lane drive bits are 0 and the data output is all zero.
- R2: With `pipe_mode` = 0, a read accepted at a clock edge drives its lanes during the cycle that follows that edge, and each driven lane shows `rd_word` combinationally.
- R3: With `pipe_mode` = 1, the drive bits appear exactly one cycle later than with `pipe_mode` = 0. Each driven lane shows the value `rd_word` had at the most recent clock edge.
- R4: An access is selected only when `ce0_n` = 0 and `ce1` = 1. A change of selection reaches the drive bits 1 edge later in flow-through timing and 2 edges later in pipelined timing.
- R5: `lane_sel_n[1]` = 1 blanks only the upper lane (bits 17:9), and `lane_sel_n[0]` = 1 blanks only the lower lane (bits 8:0). This takes effect with the same latency as the data of that access.
- R6: A write access (`rd_wr_n` = 0) drives neither lane in its output slot.
- R7: With `oe_n` = 1, both drive bits are 0 at once, without waiting for a clock edge. Returning `oe_n` to 0 restores the clocked state in the same cycle.
- R8: Every bit of a lane whose drive bit is 0 reads as 0 on `dout`.
- R9: When all inputs are held from one cycle to the next, the data output and drive bits stay constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pipe_mode | input | 1 | Static timing select: 0 flow-through, 1 pipelined; changed only under reset |
| ce0_n | input | 1 | Chip select, active low |
| ce1 | input | 1 | Chip select, active high |
| rd_wr_n | input | 1 | Access direction: 1 read, 0 write |
| lane_sel_n | input | 2 | Byte lane selects, active low; bit 1 upper lane, bit 0 lower lane |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rd_word | input | 18 | Word read from the array for the address registered at the last edge |
| dout | output | 18 | Output data; lanes that are not driven read zero |
| lane_drv | output | 2 | Per-lane drive indication (lane valid); bit 1 upper, bit 0 lower |

## Verification
Two functions can meet in one cycle: the asynchronous output-enable blanking and a clocked selection change, such as a re-select after a deselect or a write turning into a read. The bench provokes this by toggling `oe_n` both at random cycle boundaries and in the middle of a cycle while the chip-select and direction inputs change at the next edge. A behavioural model keeps the delayed access history separately for the two timing modes. On every cycle it judges the drive bits and each lane of `dout` against that history and the current `oe_n`.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  typedef enum logic {
    MODE_FLOW = 1'b0,
    MODE_PIPE = 1'b1
  } out_mode_e;
endpackage

// File: rtl/rdo_ctrl_delay.sv
// Registers the access controls and delays the per-lane "access live" state
// by one (flow-through) or two (pipelined) edges.
module rdo_ctrl_delay
  import rdo_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pipe_mode,
  input  logic             ce0_n,
  input  logic             ce1,
  input  logic             rd_wr_n,
  input  logic [LANES-1:0] lane_sel_n,
  output logic [LANES-1:0] lane_live
);
  out_mode_e mode;
  logic      chip_on;
  logic      read_on;
  logic [LANES-1:0] lane_req;
  logic [LANES-1:0] stage1_q;
  logic [LANES-1:0] stage2_q;

  assign mode    = out_mode_e'(pipe_mode);
  assign chip_on = ~ce0_n & ce1;
  assign read_on = chip_on & rd_wr_n;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_req
    assign lane_req[ln] = read_on & ~lane_sel_n[ln];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= lane_req;
      stage2_q <= stage1_q;
    end
  end

  always_comb begin
    unique case (mode)
      MODE_PIPE: lane_live = stage2_q;
      default:   lane_live = stage1_q;
    endcase
  end
endmodule

// File: rtl/rdo_word_path.sv
// Selects the array word directly (flow-through) or through one register.
module rdo_word_path
  import rdo_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] word_out
);
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= rd_word;
  end

  assign word_out = (out_mode_e'(pipe_mode) == MODE_PIPE) ? word_q : rd_word;
endmodule

// File: rtl/rdo_lane_gate.sv
// Combines the clocked lane state with the asynchronous output enable and
// zeroes every lane that is not driven.
module rdo_lane_gate #(
  parameter int DATA_W = 18,
  parameter int LANES  = 2
) (
  input  logic [DATA_W-1:0] word_in,
  input  logic [LANES-1:0]  lane_live,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout,
  output logic [LANES-1:0]  lane_drv
);
  localparam int LANE_W = DATA_W / LANES;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    assign lane_drv[ln] = lane_live[ln] & ~oe_n;
    assign dout[ln*LANE_W +: LANE_W] =
      lane_drv[ln] ? word_in[ln*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/rd_out_stage.sv
module rd_out_stage #(
  parameter int DATA_W = 18,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              ce0_n,
  input  logic              ce1,
  input  logic              rd_wr_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] dout,
  output logic [LANES-1:0]  lane_drv
);
  logic [LANES-1:0]  lane_live;
  logic [DATA_W-1:0] word_sel;

  rdo_ctrl_delay #(.LANES(LANES)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .pipe_mode  (pipe_mode),
    .ce0_n      (ce0_n),
    .ce1        (ce1),
    .rd_wr_n    (rd_wr_n),
    .lane_sel_n (lane_sel_n),
    .lane_live  (lane_live)
  );

  rdo_word_path #(.DATA_W(DATA_W)) i_word (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .rd_word   (rd_word),
    .word_out  (word_sel)
  );

  rdo_lane_gate #(.DATA_W(DATA_W), .LANES(LANES)) i_gate (
    .word_in   (word_sel),
    .lane_live (lane_live),
    .oe_n      (oe_n),
    .dout      (dout),
    .lane_drv  (lane_drv)
  );
endmodule

// File: rtl/rd_out_stage_chk.sv
module rd_out_stage_chk #(
  parameter int DATA_W = 18,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pipe_mode,
  input logic              ce0_n,
  input logic              ce1,
  input logic              rd_wr_n,
  input logic [LANES-1:0]  lane_sel_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] rd_word,
  input logic [DATA_W-1:0] dout,
  input logic [LANES-1:0]  lane_drv
);
  localparam int LW = DATA_W / LANES;

  logic [1:0]       since_rst;
  logic [LANES-1:0] acc_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assign acc_now = (!ce0_n && ce1 && rd_wr_n) ? ~lane_sel_n : '0;

  AST_OE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> lane_drv == '0); // R7
  AST_FLOW_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !oe_n && since_rst >= 2'd1) |-> lane_drv == $past(acc_now)); // R2
  AST_PIPE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && !oe_n && since_rst >= 2'd2) |-> lane_drv == $past(acc_now, 2)); // R3
  AST_FLOW_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && since_rst >= 2'd1 && $past(ce0_n)) |-> lane_drv == '0); // R4
  AST_PIPE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && since_rst >= 2'd2 && $past(ce0_n, 2)) |-> lane_drv == '0); // R4
  AST_FLOW_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && since_rst >= 2'd1 && $past(!rd_wr_n)) |-> lane_drv == '0); // R6
  AST_PIPE_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && since_rst >= 2'd2 && $past(!rd_wr_n, 2)) |-> lane_drv == '0); // R6

  for (genvar ln = 0; ln < LANES; ln++) begin : g_ln
    AST_FLOW_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (!pipe_mode && lane_drv[ln]) |-> dout[ln*LW +: LW] == rd_word[ln*LW +: LW]); // R2
    AST_PIPE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_mode && lane_drv[ln] && since_rst >= 2'd1)
        |-> dout[ln*LW +: LW] == $past(rd_word[ln*LW +: LW])); // R3
    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_drv[ln] |-> dout[ln*LW +: LW] == '0); // R8
  end
endmodule

bind rd_out_stage rd_out_stage_chk #(.DATA_W(DATA_W), .LANES(LANES)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pipe_mode  (pipe_mode),
  .ce0_n      (ce0_n),
  .ce1        (ce1),
  .rd_wr_n    (rd_wr_n),
  .lane_sel_n (lane_sel_n),
  .oe_n       (oe_n),
  .rd_word    (rd_word),
  .dout       (dout),
  .lane_drv   (lane_drv)
);

// File: tb/test_rd_out_stage.sv
`timescale 1ns/1ps
module test_rd_out_stage;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pipe_mode;
  logic        ce0_n, ce1, rd_wr_n, oe_n;
  logic [1:0]  lane_sel_n;
  logic [17:0] rd_word;
  logic [17:0] dout;
  logic [1:0]  lane_drv;

  int    errors = 0;
  int    checks = 0;
  bit    chk_on = 1'b0;
  bit    done   = 1'b0;
  string cur_req = "R1";
  logic [31:0] seed = 32'h1234_5678;

  // behavioural history: accesses one and two edges back, word one edge back
  logic [1:0]  hist1, hist2;
  logic [17:0] word1;

  always #5 clk = ~clk;

  rd_out_stage i_rd_out_stage (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .ce0_n(ce0_n), .ce1(ce1),
    .rd_wr_n(rd_wr_n), .lane_sel_n(lane_sel_n), .oe_n(oe_n), .rd_word(rd_word),
    .dout(dout), .lane_drv(lane_drv)
  );

  function automatic logic [1:0] acc_of();
    return (ce0_n == 1'b0 && ce1 == 1'b1 && rd_wr_n == 1'b1) ? ~lane_sel_n : 2'b00;
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed ^ (seed >> 15);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist1 <= '0; hist2 <= '0; word1 <= '0;
    end else begin
      hist2 <= hist1;
      hist1 <= acc_of();
      word1 <= rd_word;
    end
  end

  function automatic logic [1:0] exp_lanes();
    logic [1:0] l;
    l = pipe_mode ? hist2 : hist1;
    return oe_n ? 2'b00 : l;
  endfunction

  function automatic logic [17:0] exp_data();
    logic [1:0]  l;
    logic [17:0] w;
    l = exp_lanes();
    w = pipe_mode ? word1 : rd_word;
    return {l[1] ? w[17:9] : 9'd0, l[0] ? w[8:0] : 9'd0};
  endfunction

  task automatic chk(input string req, input logic [17:0] a_d, e_d,
                     input logic [1:0] a_l, e_l);
    checks++;
    if (a_d !== e_d || a_l !== e_l) begin
      errors++;
      $display("FAIL %s: dout=%h lane_drv=%b expected dout=%h lane_drv=%b",
               req, a_d, a_l, e_d, e_l);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && rst_n) chk(cur_req, dout, exp_data(), lane_drv, exp_lanes());
  end

  task automatic drive(input logic c0n, c1, rw, input logic [1:0] bs,
                       input logic [17:0] w);
    @(posedge clk); #2;
    ce0_n = c0n; ce1 = c1; rd_wr_n = rw; lane_sel_n = bs; rd_word = w;
  endtask

  task automatic do_reset(input logic mode);
    chk_on = 1'b0;
    @(posedge clk); #2;
    rst_n = 1'b0; pipe_mode = mode; oe_n = 1'b0;
    ce0_n = 1'b1; ce1 = 1'b0; rd_wr_n = 1'b1; lane_sel_n = 2'b11; rd_word = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #3 chk("R1 reset state", dout, 18'd0, lane_drv, 2'b00);
    chk_on = 1'b1;
  endtask

  task automatic run_set(input string lat);
    logic [31:0] r;
    logic [17:0] held_d;
    logic [1:0]  held_l;
    cur_req = {lat, " read"};
    for (int i = 0; i < 20; i++) begin r = rnd(); drive(1'b0, 1'b1, 1'b1, 2'b00, r[17:0]); end
    cur_req = {lat, " R5 R8 byte lanes"};
    for (int i = 0; i < 24; i++) begin r = rnd(); drive(1'b0, 1'b1, 1'b1, r[21:20], r[17:0]); end
    cur_req = {lat, " R4 chip select"};
    for (int i = 0; i < 24; i++) begin r = rnd(); drive(r[20], r[21] | r[22], 1'b1, 2'b00, r[17:0]); end
    cur_req = {lat, " R6 write slots"};
    for (int i = 0; i < 24; i++) begin r = rnd(); drive(1'b0, 1'b1, r[20], r[22:21], r[17:0]); end
    cur_req = {lat, " R7 oe at edges"};
    for (int i = 0; i < 24; i++) begin
      r = rnd(); drive(r[23], 1'b1, r[20], r[22:21], r[17:0]); oe_n = r[24];
    end
    oe_n = 1'b0;
    // R7: blank and restore inside one cycle, no edge in between
    r = rnd();
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, 1'b1, 2'b00, r[17:0]);
    @(posedge clk); #2 oe_n = 1'b1;
    #1 chk({lat, " R7 async blank"}, dout, 18'd0, lane_drv, 2'b00);
    #1 oe_n = 1'b0;
    #1 chk({lat, " R7 async restore"}, dout, r[17:0], lane_drv, 2'b11);
    // R9: held inputs keep the output constant
    cur_req = {lat, " R9 hold"};
    r = rnd();
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, 1'b1, 2'b10, r[17:0]);
    @(negedge clk); #1 held_d = dout; held_l = lane_drv;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1 chk({lat, " R9 held output"}, dout, held_d, lane_drv, held_l);
    end
  endtask

  initial begin
    do_reset(1'b0);
    run_set("R2");
    do_reset(1'b1);
    run_set("R3");
    chk_on = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule